// File: doc/BRIEF.md
# Per-Core Compare Timer

This block is the deadline timer that sits beside one processor core. A free-running system count arrives from outside, shared by all cores. Software programs a deadline, and the block raises a level interrupt toward the interrupt controller once the count has reached that deadline. The deadline can be set in two ways. One is an absolute compare value as wide as the count. The other is a signed relative value, which is added to the live count when written. On read it returns the remaining distance to the deadline.

A small control word holds an enable bit, a mask bit and a read-only status bit. The block also keeps two registers that belong to the shared counter: a frequency word and a kernel-control word. While the frequency word is zero, the count is treated as zero everywhere. Software reaches everything through a single-cycle register port. Read data is combinational from the select. A write takes effect on the next rising clock edge. Both count selects are read-only. Selects for timer instances that are not built here read as zero and ignore writes.

Top module: `core_cmp_timer`

## Requirements
- R1: After reset the frequency word equals FREQ_RESET (default 0x01800000), the kernel-control word and the compare value are zero, enable and mask are zero, and `irq_o` is low.
- R2: The control word (select 4) has enable at bit 0, mask at bit 1 and status at bit 2. A write changes only enable and mask, and status ignores the written bit 2.
- R3: At each rising edge, status becomes set if the effective count in the cycle before was greater than or equal to the compare value. Once set, status stays set until the next compare or relative write.
- R4: A write to the compare value (select 2) loads the written data. At that same edge, status becomes (effective count >= new compare value): set when true, cleared otherwise.
- R5: `irq_o` is the level status AND enable AND NOT mask. It falls at the edge where mask is set, enable is cleared or status is cleared.
- R6: A write to the relative value (select 3) loads the compare value with the effective count plus the low REL_W bits of the write data, sign-extended to CNT_W bits, modulo 2^CNT_W. Status is evaluated as in R4.
- R7: A read of the relative value returns (compare value − effective count) truncated to REL_W bits and zero-extended.
- R8: While the frequency word is zero, the effective count is zero. It is zero both for count reads and for the compare evaluation.
- R9: Selects 5 (physical count) and 6 (virtual count) both read the effective count. Writes to them change no register.
- R10: Selects 7 to 15 read as zero. Writes to them change no register.
- R11: The kernel-control word (select 1) stores the low KCTL_W bits written and reads them back zero-extended.
- R12: The frequency word (select 0) stores the low FREQ_W bits written and reads them back zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | CNT_W | Shared free-running system count |
| we_i | input | 1 | Register write strobe |
| sel_i | input | 4 | Register select |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Combinational read data for `sel_i` |
| irq_o | output | 1 | Level timer interrupt |

## Verification
The bench builds the block with CNT_W=12, REL_W=6 and FREQ_W=KCTL_W=12, with a reset frequency of 0x180. At these widths every relative value (all 64 codes) can be swept at two base counts, one of them near zero so that negative offsets wrap. Compare offsets around the live count and count ramps across the deadline are walked cycle by cycle. All four enable/mask combinations are tried with status both set and clear. Every unimplemented select is written and read.

// File: rtl/ct_pkg.sv
package ct_pkg;

  typedef enum logic [3:0] {
    SEL_FREQ = 4'd0,
    SEL_KCTL = 4'd1,
    SEL_CMP  = 4'd2,
    SEL_REL  = 4'd3,
    SEL_CTRL = 4'd4,
    SEL_PCNT = 4'd5,
    SEL_VCNT = 4'd6
  } ct_sel_e;

  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_MASK_BIT = 1;
  localparam int unsigned CTL_STAT_BIT = 2;

  typedef struct packed {
    logic freq_we;
    logic kctl_we;
    logic cmp_we;
    logic rel_we;
    logic ctrl_we;
  } ct_wr_t;

endpackage

// File: rtl/ct_shared_regs.sv
module ct_shared_regs #(
  parameter int unsigned CNT_W      = 64,
  parameter int unsigned FREQ_W     = 32,
  parameter int unsigned KCTL_W     = 32,
  parameter logic [FREQ_W-1:0] FREQ_RESET = 'h0180_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freq_we_i,
  input  logic              kctl_we_i,
  input  logic [FREQ_W-1:0] freq_wdata_i,
  input  logic [KCTL_W-1:0] kctl_wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [FREQ_W-1:0] freq_o,
  output logic [KCTL_W-1:0] kctl_o,
  output logic [CNT_W-1:0]  eff_count_o
);

  logic [FREQ_W-1:0] freq_q, freq_d;
  logic [KCTL_W-1:0] kctl_q, kctl_d;
  logic              cnt_run;

  always_comb begin
    freq_d = freq_q;
    kctl_d = kctl_q;
    if (freq_we_i) freq_d = freq_wdata_i;
    if (kctl_we_i) kctl_d = kctl_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= FREQ_RESET;
    end else if (freq_we_i) begin
      freq_q <= freq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kctl_q <= '0;
    end else if (kctl_we_i) begin
      kctl_q <= kctl_d;
    end
  end

  assign cnt_run     = (freq_q != '0);
  assign eff_count_o = cnt_run ? count_i : '0;
  assign freq_o      = freq_q;
  assign kctl_o      = kctl_q;

  AST_KCTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !kctl_we_i |=> $stable(kctl_o)); // R11
  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_we_i |=> $stable(freq_o)); // R12

endmodule

// File: rtl/ct_cmp_core.sv
module ct_cmp_core #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned REL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_we_i,
  input  logic             rel_we_i,
  input  logic             ctrl_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] eff_count_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic [REL_W-1:0] rel_o,
  output logic [2:0]       ctrl_o,
  output logic             irq_o
);
  import ct_pkg::*;

  localparam int unsigned EXT_W = CNT_W - REL_W;

  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0] rel_sext;
  logic [CNT_W-1:0] distance;
  logic             cmp_load;
  logic             cond_now, cond_new;
  logic             stat_q, stat_d;
  logic             en_q, en_d, mask_q, mask_d;

  assign rel_sext = {{EXT_W{wdata_i[REL_W-1]}}, wdata_i[REL_W-1:0]};

  // next-state: deadline
  always_comb begin
    cmp_d    = cmp_q;
    cmp_load = 1'b0;
    if (cmp_we_i) begin
      cmp_d    = wdata_i;
      cmp_load = 1'b1;
    end else if (rel_we_i) begin
      cmp_d    = eff_count_i + rel_sext;
      cmp_load = 1'b1;
    end
  end

  assign cond_now = (eff_count_i >= cmp_q);
  assign cond_new = (eff_count_i >= cmp_d);

  // next-state: status and control
  always_comb begin
    stat_d = cmp_load ? cond_new : (stat_q | cond_now);
    en_d   = en_q;
    mask_d = mask_q;
    if (ctrl_we_i) begin
      en_d   = wdata_i[CTL_EN_BIT];
      mask_d = wdata_i[CTL_MASK_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (cmp_load) begin
      cmp_q <= cmp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else if (ctrl_we_i) begin
      en_q   <= en_d;
      mask_q <= mask_d;
    end
  end

  assign distance = cmp_q - eff_count_i;
  assign rel_o    = distance[REL_W-1:0];
  assign cmp_o    = cmp_q;

  always_comb begin
    ctrl_o               = '0;
    ctrl_o[CTL_EN_BIT]   = en_q;
    ctrl_o[CTL_MASK_BIT] = mask_q;
    ctrl_o[CTL_STAT_BIT] = stat_q;
  end

  assign irq_o = stat_q & en_q & ~mask_q;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_load && ctrl_o[CTL_STAT_BIT]) |=> ctrl_o[CTL_STAT_BIT]); // R3
  AST_REACHED_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_load && eff_count_i >= cmp_o) |=> ctrl_o[CTL_STAT_BIT]); // R3
  AST_LOAD_FUTURE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we_i && eff_count_i < wdata_i) |=> !ctrl_o[CTL_STAT_BIT]); // R4
  AST_LOAD_PAST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we_i && eff_count_i >= wdata_i) |=> ctrl_o[CTL_STAT_BIT]); // R4
  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_o[CTL_MASK_BIT]) |-> !irq_o); // R5
  AST_DISABLE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_o[CTL_EN_BIT]) |-> !irq_o); // R5

endmodule

// File: rtl/ct_regdec.sv
module ct_regdec #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned REL_W  = 32,
  parameter int unsigned FREQ_W = 32,
  parameter int unsigned KCTL_W = 32
) (
  input  logic              we_i,
  input  logic [3:0]        sel_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [KCTL_W-1:0] kctl_i,
  input  logic [CNT_W-1:0]  cmp_i,
  input  logic [REL_W-1:0]  rel_i,
  input  logic [2:0]        ctrl_i,
  input  logic [CNT_W-1:0]  eff_count_i,
  output ct_pkg::ct_wr_t    wr_o,
  output logic [CNT_W-1:0]  rdata_o
);
  import ct_pkg::*;

  always_comb begin
    wr_o = '0;
    if (we_i) begin
      case (sel_i)
        SEL_FREQ: wr_o.freq_we = 1'b1;
        SEL_KCTL: wr_o.kctl_we = 1'b1;
        SEL_CMP:  wr_o.cmp_we  = 1'b1;
        SEL_REL:  wr_o.rel_we  = 1'b1;
        SEL_CTRL: wr_o.ctrl_we = 1'b1;
        default:  wr_o = '0;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SEL_FREQ: rdata_o[FREQ_W-1:0] = freq_i;
      SEL_KCTL: rdata_o[KCTL_W-1:0] = kctl_i;
      SEL_CMP:  rdata_o             = cmp_i;
      SEL_REL:  rdata_o[REL_W-1:0]  = rel_i;
      SEL_CTRL: rdata_o[2:0]        = ctrl_i;
      SEL_PCNT,
      SEL_VCNT: rdata_o             = eff_count_i;
      default:  rdata_o             = '0;
    endcase
  end

endmodule

// File: rtl/core_cmp_timer.sv
module core_cmp_timer #(
  parameter int unsigned CNT_W      = 64,
  parameter int unsigned REL_W      = 32,
  parameter int unsigned FREQ_W     = 32,
  parameter int unsigned KCTL_W     = 32,
  parameter logic [FREQ_W-1:0] FREQ_RESET = 'h0180_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             we_i,
  input  logic [3:0]       sel_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  import ct_pkg::*;

  ct_wr_t            wr;
  logic [FREQ_W-1:0] freq_val;
  logic [KCTL_W-1:0] kctl_val;
  logic [CNT_W-1:0]  eff_count;
  logic [CNT_W-1:0]  cmp_val;
  logic [REL_W-1:0]  rel_val;
  logic [2:0]        ctrl_val;

  ct_shared_regs #(
    .CNT_W(CNT_W), .FREQ_W(FREQ_W), .KCTL_W(KCTL_W), .FREQ_RESET(FREQ_RESET)
  ) u_shared (
    .clk          (clk),
    .rst_n        (rst_n),
    .freq_we_i    (wr.freq_we),
    .kctl_we_i    (wr.kctl_we),
    .freq_wdata_i (wdata_i[FREQ_W-1:0]),
    .kctl_wdata_i (wdata_i[KCTL_W-1:0]),
    .count_i      (count_i),
    .freq_o       (freq_val),
    .kctl_o       (kctl_val),
    .eff_count_o  (eff_count)
  );

  ct_cmp_core #(.CNT_W(CNT_W), .REL_W(REL_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_we_i    (wr.cmp_we),
    .rel_we_i    (wr.rel_we),
    .ctrl_we_i   (wr.ctrl_we),
    .wdata_i     (wdata_i),
    .eff_count_i (eff_count),
    .cmp_o       (cmp_val),
    .rel_o       (rel_val),
    .ctrl_o      (ctrl_val),
    .irq_o       (irq_o)
  );

  ct_regdec #(
    .CNT_W(CNT_W), .REL_W(REL_W), .FREQ_W(FREQ_W), .KCTL_W(KCTL_W)
  ) u_dec (
    .we_i        (we_i),
    .sel_i       (sel_i),
    .freq_i      (freq_val),
    .kctl_i      (kctl_val),
    .cmp_i       (cmp_val),
    .rel_i       (rel_val),
    .ctrl_i      (ctrl_val),
    .eff_count_i (eff_count),
    .wr_o        (wr),
    .rdata_o     (rdata_o)
  );

  AST_COUNT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (sel_i == SEL_PCNT || sel_i == SEL_VCNT))
      |=> ($stable(cmp_val) && $stable(freq_val) && $stable(kctl_val))); // R9
  AST_UNIMPL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i > SEL_VCNT) |-> (rdata_o == '0)); // R10
  AST_UNIMPL_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i > SEL_VCNT)
      |=> ($stable(cmp_val) && $stable(ctrl_val[1:0]) && $stable(kctl_val))); // R10
  AST_FREQ_OFF_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_val == '0 && sel_i == SEL_PCNT) |-> (rdata_o == '0)); // R8

endmodule

// File: tb/core_cmp_timer_bench.sv
module core_cmp_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt = '0;
  logic         we = 1'b0;
  logic [3:0]   sel = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_cmp_timer #(
    .CNT_W(W), .REL_W(6), .FREQ_W(W), .KCTL_W(W), .FREQ_RESET(12'h180)
  ) u_core_cmp_timer (
    .clk(clk), .rst_n(rst_n), .count_i(cnt), .we_i(we),
    .sel_i(sel), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [W-1:0] d);
    @(negedge clk);
    sel = s; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [W-1:0] d);
    sel = s;
    #1;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] exp;
    logic         seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'd0, v); chk("R1 freq", v, 12'h180);
    rd(4'd1, v); chk("R1 kctl", v, 12'h000);
    rd(4'd2, v); chk("R1 compare", v, 12'h000);
    rd(4'd4, v); chk("R1 enable/mask", v & 12'h3, 12'h000);
    chk("R1 irq", {11'd0, irq}, 12'h000);

    // R12, R11 storage
    wr(4'd0, 12'hA5C); rd(4'd0, v); chk("R12 freq readback", v, 12'hA5C);
    wr(4'd1, 12'h3C7); rd(4'd1, v); chk("R11 kctl readback", v, 12'h3C7);
    wr(4'd1, 12'hFFF); rd(4'd1, v); chk("R11 kctl all ones", v, 12'hFFF);

    // R4 compare write evaluation around the live count
    cnt = 12'd100;
    for (int d = -3; d <= 3; d++) begin
      logic [W-1:0] c;
      c = 12'(100 + d);
      wr(4'd2, c);
      rd(4'd2, v); chk("R4 compare readback", v, c);
      rd(4'd4, v); chk("R4 status after write", {11'd0, v[2]}, (d <= 0) ? 12'd1 : 12'd0);
    end

    // R3 count ramp across the deadline, sticky status
    cnt = 12'd195;
    wr(4'd2, 12'd200);
    seen = 1'b0;
    for (int k = 195; k <= 206; k++) begin
      @(negedge clk);
      cnt = (k == 203) ? 12'd10 : 12'(k);
      if (k >= 200 && k != 203) seen = 1'b1;
      @(negedge clk);
      rd(4'd4, v);
      chk("R3 status on ramp", {11'd0, v[2]}, {11'd0, seen});
    end

    // R5 / R2 all enable-mask combinations with status set and clear
    cnt = 12'd100;
    for (int s = 0; s < 2; s++) begin
      wr(4'd2, (s == 1) ? 12'd50 : 12'd900);
      for (int m = 0; m < 4; m++) begin
        wr(4'd4, 12'(m));
        rd(4'd4, v);
        chk("R2 control fields", v, 12'(m + 4 * s));
        chk("R5 irq level", {11'd0, irq}, (s == 1 && m == 1) ? 12'd1 : 12'd0);
      end
    end
    // R2 status bit not writable
    wr(4'd2, 12'd900);
    wr(4'd4, 12'h7);
    rd(4'd4, v); chk("R2 status read-only", v, 12'h3);
    // R5 irq rises when count reaches deadline, drops on mask / disable
    wr(4'd4, 12'h1);
    chk("R5 irq idle", {11'd0, irq}, 12'd0);
    @(negedge clk); cnt = 12'd900;
    @(negedge clk); chk("R5 irq after deadline", {11'd0, irq}, 12'd1);
    wr(4'd4, 12'h3); chk("R5 irq masked", {11'd0, irq}, 12'd0);
    wr(4'd4, 12'h1); chk("R5 irq unmasked", {11'd0, irq}, 12'd1);
    wr(4'd4, 12'h0); chk("R5 irq disabled", {11'd0, irq}, 12'd0);
    wr(4'd4, 12'h1);
    wr(4'd2, 12'd950); chk("R5 irq after future compare", {11'd0, irq}, 12'd0);

    // R6 / R7 sweep of every relative code at two base counts
    for (int b = 0; b < 2; b++) begin
      cnt = (b == 0) ? 12'd2000 : 12'd5;
      for (int r = 0; r < 64; r++) begin
        logic [5:0] rv;
        rv = 6'(r);
        wr(4'd3, {6'd0, rv});
        exp = cnt + {{6{rv[5]}}, rv};
        rd(4'd2, v); chk("R6 relative load", v, exp);
        rd(4'd3, v); chk("R7 relative read", v, {6'd0, rv});
        rd(4'd4, v); chk("R6 status after relative", {11'd0, v[2]}, (cnt >= exp) ? 12'd1 : 12'd0);
      end
    end
    // R7 read as count moves
    cnt = 12'd300;
    wr(4'd2, 12'd310);
    cnt = 12'd305; rd(4'd3, v); chk("R7 remaining distance", v, 12'd5);
    cnt = 12'd320; rd(4'd3, v); chk("R7 negative distance", v, 12'h036);

    // R9 count registers
    cnt = 12'd777;
    rd(4'd5, v); chk("R9 physical count", v, 12'd777);
    rd(4'd6, v); chk("R9 virtual count", v, 12'd777);
    wr(4'd5, 12'd1); wr(4'd6, 12'd2);
    rd(4'd5, v); chk("R9 count write ignored", v, 12'd777);
    rd(4'd2, v); chk("R9 compare untouched", v, 12'd310);
    rd(4'd0, v); chk("R9 freq untouched", v, 12'hA5C);

    // R8 frequency zero stops the count
    wr(4'd0, 12'd0);
    rd(4'd5, v); chk("R8 count reads zero", v, 12'd0);
    rd(4'd6, v); chk("R8 virtual reads zero", v, 12'd0);
    wr(4'd2, 12'd5);
    rd(4'd4, v); chk("R8 compare uses zero count", {11'd0, v[2]}, 12'd0);
    wr(4'd3, 12'd3);
    rd(4'd2, v); chk("R8 relative uses zero count", v, 12'd3);
    wr(4'd0, 12'h180);
    rd(4'd5, v); chk("R8 count resumes", v, 12'd777);

    // R10 unimplemented selects
    wr(4'd2, 12'd1234);
    wr(4'd4, 12'd2);
    for (int s = 7; s < 16; s++) begin
      wr(4'(s), 12'hFFF);
      rd(4'(s), v); chk("R10 unimplemented reads zero", v, 12'd0);
    end
    rd(4'd2, v); chk("R10 compare untouched", v, 12'd1234);
    rd(4'd4, v); chk("R10 control untouched", v & 12'h3, 12'd2);
    rd(4'd1, v); chk("R10 kctl untouched", v, 12'hFFF);
    rd(4'd0, v); chk("R10 freq untouched", v, 12'h180);

    finish_run();
  end

endmodule